// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of one read or write burst to a double-data-rate memory, one address per clock cycle. A controller pulses a start input together with a starting column address, a burst length choice (four or eight beats) and an ordering choice (sequential or interleaved). The block then presents the beat addresses in order, each flagged valid, and marks the final beat.

Only the low column bits inside the burst window move. For a four-beat burst these are bits 1:0. For an eight-beat burst they are bits 2:0. Every bit above the window is copied from the starting address onto each beat.

Sequential eight-beat bursts wrap inside the starting group of four and then cover the other group of four. Interleaved bursts XOR the beat number into the starting low bits. Length and ordering are captured at start. The block ignores starts that arrive while a burst is running.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is high, and in the cycle after it is released with no start, `valid_o`, `last_o` and `busy_o` are low.
- R2: A start sampled while `busy_o` is low makes `valid_o` go high on the next cycle. That first beat carries the starting column address unchanged.
- R3: With `bl8_i`=0 and `ilv_i`=0 (four beats, sequential), beat k has bits 1:0 equal to (start[1:0]+k) mod 4. Bit 2 keeps its start value. Example: start 1 gives 1,2,3,0.
- R4: With `bl8_i`=0 and `ilv_i`=1 (four beats, interleaved), beat k has bits 1:0 equal to start[1:0] XOR k. Example: start 1 gives 1,0,3,2.
- R5: With `bl8_i`=1 and `ilv_i`=0 (eight beats, sequential), beat k has bits 1:0 equal to (start[1:0]+(k mod 4)) mod 4. Bit 2 equals start[2] XOR (k≥4). Example: start 1 gives 1,2,3,0,5,6,7,4.
- R6: With `bl8_i`=1 and `ilv_i`=1 (eight beats, interleaved), beat k has bits 2:0 equal to start[2:0] XOR k. Example: start 5 gives 5,4,7,6,1,0,3,2.
- R7: Column bits from bit 3 upward equal the starting address on every beat.
- R8: `valid_o` stays high for exactly 4 consecutive cycles (`bl8_i`=0) or 8 consecutive cycles (`bl8_i`=1), one beat per cycle. `last_o` is high on the final beat only. `valid_o` is low in the cycle after the final beat.
- R9: `busy_o` is high in exactly the cycles where a beat is valid. A start sampled while `busy_o` is high has no effect on the running sequence. A start sampled in the first cycle after the final beat is accepted.
- R10: `bl8_i`, `ilv_i` and `col_i` are sampled only at an accepted start. Changing them during a burst leaves the remaining beats unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse for a new burst |
| col_i | input | COL_W | Starting column address |
| bl8_i | input | 1 | 1 = eight-beat burst, 0 = four-beat burst |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential order |
| valid_o | output | 1 | Beat address on `col_o` is valid |
| col_o | output | COL_W | Column address of the current beat |
| last_o | output | 1 | Final beat of the burst |
| busy_o | output | 1 | Burst in progress; starts are ignored |

## Verification
The bench builds the block with `COL_W` set to 5. That leaves two bits above the eight-beat window, so random starting addresses hit every low-bit start value and all upper-bit patterns, including all ones, in a few dozen bursts. It also means a fault that leaks the window into bit 3 or 4 shows up directly.

While a burst is running, the random stimulus toggles the start, length, ordering and address inputs. The directed bursts cover the example orders and back-to-back starts.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int WIN_W = 3;
  typedef logic [WIN_W-1:0] win_t;
  typedef enum logic {ORD_SEQ = 1'b0, ORD_ILV = 1'b1} ord_e;
endpackage

// File: rtl/bseq_order.sv
module bseq_order
  import burst_seq_pkg::*;
(
  input  win_t start_lo,
  input  win_t beat,
  input  ord_e ord,
  output win_t lo
);
  always_comb begin
    if (ord == ORD_ILV) begin
      lo = start_lo ^ beat;
    end else begin
      // Nibble wrap: low pair counts modulo 4, the group bit flips after beat 3.
      lo[1:0] = start_lo[1:0] + beat[1:0];
      lo[2]   = start_lo[2] ^ beat[2];
    end
  end
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic bl8_i,
  output logic accept_o,
  output logic adv_o,
  output logic active_o,
  output logic last_o,
  output win_t nxt_beat_o
);
  logic active_q, last_q, bl8_q;
  win_t beat_q, beat_max;

  assign beat_max   = bl8_q ? win_t'(7) : win_t'(3);
  assign accept_o   = start_i & ~active_q;
  assign adv_o      = active_q & ~last_q;
  assign nxt_beat_o = accept_o ? '0 : win_t'(beat_q + 1'b1);
  assign active_o   = active_q;
  assign last_o     = last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      last_q   <= 1'b0;
      bl8_q    <= 1'b0;
      beat_q   <= '0;
    end else if (accept_o) begin
      active_q <= 1'b1;
      last_q   <= 1'b0;
      bl8_q    <= bl8_i;
      beat_q   <= '0;
    end else if (active_q) begin
      if (last_q) begin
        active_q <= 1'b0;
        last_q   <= 1'b0;
      end else begin
        beat_q <= nxt_beat_o;
        last_q <= (nxt_beat_o == beat_max);
      end
    end
  end

  a_r8_beat_step: assert property (@(posedge clk) disable iff (rst)
    active_q && !last_q |=> active_q && (beat_q == win_t'($past(beat_q) + 1'b1)));
  a_r8_last_at_max: assert property (@(posedge clk) disable iff (rst)
    last_q |-> beat_q == (bl8_q ? win_t'(7) : win_t'(3)));
  a_r10_len_held: assert property (@(posedge clk) disable iff (rst)
    active_q && $past(active_q) && !$past(last_q) |-> $stable(bl8_q));
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             bl8_i,
  input  logic             ilv_i,
  output logic             valid_o,
  output logic [COL_W-1:0] col_o,
  output logic             last_o,
  output logic             busy_o
);
  localparam int UP_W = COL_W - WIN_W;

  logic accept, adv, active, last;
  win_t nxt_beat, start_lo_q, sel_lo, ord_lo;
  ord_e ord_q, sel_ord;
  logic [COL_W-1:0] col_q;
  logic [UP_W-1:0]  sel_up;

  bseq_beat_ctr u_ctr (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .bl8_i      (bl8_i),
    .accept_o   (accept),
    .adv_o      (adv),
    .active_o   (active),
    .last_o     (last),
    .nxt_beat_o (nxt_beat)
  );

  assign sel_lo  = accept ? col_i[WIN_W-1:0] : start_lo_q;
  assign sel_ord = accept ? ord_e'(ilv_i) : ord_q;
  assign sel_up  = accept ? col_i[COL_W-1:WIN_W] : col_q[COL_W-1:WIN_W];

  bseq_order u_ord (
    .start_lo (sel_lo),
    .beat     (nxt_beat),
    .ord      (sel_ord),
    .lo       (ord_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q      <= '0;
      start_lo_q <= '0;
      ord_q      <= ORD_SEQ;
    end else if (accept || adv) begin
      col_q      <= {sel_up, ord_lo};
      start_lo_q <= sel_lo;
      ord_q      <= sel_ord;
    end
  end

  assign valid_o = active;
  assign busy_o  = active;
  assign last_o  = last;
  assign col_o   = col_q;

  a_r7_upper_hold: assert property (@(posedge clk) disable iff (rst)
    valid_o && $past(valid_o) && !$past(last_o)
      |-> col_o[COL_W-1:WIN_W] == $past(col_o[COL_W-1:WIN_W]));
  a_r3_seq_step: assert property (@(posedge clk) disable iff (rst)
    valid_o && $past(valid_o) && !$past(last_o) && ord_q == ORD_SEQ
      |-> col_o[1:0] == 2'($past(col_o[1:0]) + 2'd1));
  a_r4_ilv_toggle: assert property (@(posedge clk) disable iff (rst)
    valid_o && $past(valid_o) && !$past(last_o) && ord_q == ORD_ILV
      |-> col_o[0] != $past(col_o[0]));
  a_r8_last_valid: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);
  a_r8_end: assert property (@(posedge clk) disable iff (rst)
    last_o |=> !valid_o);
  a_r9_busy_match: assert property (@(posedge clk) disable iff (rst)
    busy_o == valid_o);
endmodule

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [CW-1:0] col_i = '0;
  logic bl8_i = 1'b0;
  logic ilv_i = 1'b0;
  logic valid_o, last_o, busy_o;
  logic [CW-1:0] col_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_col_seq #(.COL_W(CW)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .col_i(col_i),
    .bl8_i(bl8_i), .ilv_i(ilv_i), .valid_o(valid_o), .col_o(col_o),
    .last_o(last_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] exp_col(input logic [CW-1:0] c, input bit bl8,
                                            input bit ilv, input int k);
    int lo, r;
    lo = int'(c[2:0]);
    if (ilv) r = lo ^ k;
    else     r = ((lo / 4 + k / 4) % 2) * 4 + ((lo % 4) + (k % 4)) % 4;
    if (!bl8) r = (r % 4) + (lo / 4) * 4;
    return {c[CW-1:3], 3'(r)};
  endfunction

  function automatic string mode_req(input bit bl8, input bit ilv);
    if (!bl8) return ilv ? "R4" : "R3";
    return ilv ? "R6" : "R5";
  endfunction

  // Entered at a falling edge with the block idle; returns at a falling edge, idle.
  task automatic run_burst(input logic [CW-1:0] c, input bit bl8, input bit ilv, input bit noise);
    int n;
    n = bl8 ? 8 : 4;
    start_i = 1'b1; col_i = c; bl8_i = bl8; ilv_i = ilv;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (noise && k < n - 1) begin
        start_i = 1'($urandom);
        bl8_i   = 1'($urandom);
        ilv_i   = 1'($urandom);
        col_i   = CW'($urandom);
      end else begin
        start_i = 1'b0;
      end
      chk(valid_o === 1'b1, (k == 0) ? "R2 valid" : "R8 valid", int'(valid_o), 1);
      chk(busy_o === 1'b1, "R9 busy", int'(busy_o), 1);
      chk(col_o[2:0] === exp_col(c, bl8, ilv, k) [2:0], mode_req(bl8, ilv),
          int'(col_o[2:0]), int'(exp_col(c, bl8, ilv, k) [2:0]));
      chk(col_o[CW-1:3] === c[CW-1:3], "R7 upper", int'(col_o[CW-1:3]), int'(c[CW-1:3]));
      if (noise) chk(col_o === exp_col(c, bl8, ilv, k), "R10 held", int'(col_o),
                     int'(exp_col(c, bl8, ilv, k)));
      chk(last_o === (k == n - 1), "R8 last", int'(last_o), int'(k == n - 1));
    end
    @(negedge clk);
    chk(valid_o === 1'b0, "R8 end", int'(valid_o), 0);
    chk(busy_o === 1'b0, "R9 idle", int'(busy_o), 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    start_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(valid_o === 1'b0 && last_o === 1'b0 && busy_o === 1'b0, "R1 in reset",
        int'({valid_o, last_o, busy_o}), 0);
    rst = 1'b0; start_i = 1'b0;
    @(negedge clk);
    chk(valid_o === 1'b0 && last_o === 1'b0 && busy_o === 1'b0, "R1 after reset",
        int'({valid_o, last_o, busy_o}), 0);
    // Directed example orders, run back to back (R9 re-accept).
    run_burst(5'b11001, 1'b0, 1'b0, 1'b0);
    run_burst(5'b00001, 1'b0, 1'b1, 1'b0);
    run_burst(5'b10001, 1'b1, 1'b0, 1'b0);
    run_burst(5'b01101, 1'b1, 1'b1, 1'b0);
    run_burst(5'b11111, 1'b1, 1'b0, 1'b0);
    run_burst(5'b11111, 1'b0, 1'b1, 1'b1);
    run_burst(5'b00000, 1'b1, 1'b1, 1'b1);
    // Random bursts with input noise during the beats (R9, R10).
    for (int i = 0; i < 80; i++) begin
      run_burst(CW'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      if ((i % 7) == 0) begin
        repeat (2) @(negedge clk);
        chk(valid_o === 1'b0, "R9 stays idle", int'(valid_o), 0);
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule